// File: doc/BRIEF.md
# Multi-Table Page Translator

This block sits between an 8-bit CPU and a 1 MB physical memory system. It cuts the 64 KB CPU address space into sixteen 4 KB pages. Each page is mapped onto an 8-bit physical page number, and the 12-bit page offset is carried through unchanged. All mappings live in an internal translation store that keeps many complete page tables at once. One write to a select port swaps in a whole 16-page map, so the CPU never has to reprogram the entries one at a time.

Every table has two halves: a read map and a write map. The direction of the current memory access picks the half. A region can therefore be read from ROM while writes to the same CPU addresses land in RAM, which makes copying ROM into RAM easy. A write-map entry can carry a protect flag. A write to a protected page raises an inhibit output that gates off the memory write strobe, and it also sets a sticky fault flag that only a dedicated port write clears.

Entries are loaded through two I/O ports. A pointer write names the table, the direction and the page. A following data write then stores the entry at that location. The upper byte of the I/O address carries the fields that do not fit in the 8-bit data byte.

Top module: `page_xlat_mmu`

## Requirements
- R1: Bits `cpu_addr[15:12]` choose one of 16 entries, and `phys_addr[11:0]` always equals `cpu_addr[11:0]`. The entry's page number drives `phys_addr[19:12]`.
- R2: After reset, every page of table 0's read map points to physical page `BOOT_PPN` (default 8'hF0). Every other entry holds page 0 with no protect flag. Table 0 is active, and both `wp_fault` and `wr_inhibit` are low.
- R3: An I/O write to port `PORT_PTR` (8'h41) sets the load pointer. The table number is the low `TBL_W` bits of `cpu_din`. The direction is `cpu_addr[12]` (0 = read map, 1 = write map). The page is `cpu_addr[11:8]`.
- R4: An I/O write to port `PORT_DATA` (8'h42) stores an entry at the pointer. The page number comes from `cpu_din`, and the protect flag comes from `cpu_addr[8]`. Entries of tables that are not active keep their values until they are rewritten.
- R5: A memory access with `wr`=0 is translated through the read map of the active table. One with `wr`=1 is translated through the write map of the same table.
- R6: An I/O write to port `PORT_SEL` (8'h40) stores the low `TBL_W` bits of `cpu_din` as the pending table. The pending table becomes active only on the next rising edge of `mreq`. A memory access already in progress keeps its table.
- R7: `wr_inhibit` is high exactly while `mreq` and `wr` are high and the write-map entry of the addressed page has its protect flag set.
- R8: A protect flag stored in a read-map entry has no effect: reads never raise `wr_inhibit`.
- R9: `wp_fault` sets in the clock edge after an inhibited write and stays set until an I/O write to port `PORT_CLR` (8'h43). Accesses and writes to other ports leave it set.
- R10: I/O writes act only when `iorq` and `wr` are both high, and port numbers are taken from `cpu_addr[7:0]`. A memory write whose low address byte matches a port number changes nothing, and neither does an I/O write to any other port number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address; low byte is the port number for I/O |
| cpu_din | input | 8 | CPU write data |
| mreq | input | 1 | Memory cycle strobe, active high |
| iorq | input | 1 | I/O cycle strobe, active high |
| wr | input | 1 | Access direction: 1 = write, 0 = read |
| phys_addr | output | 20 | Translated physical address |
| wr_inhibit | output | 1 | Blocks the memory write strobe for a protected page |
| wp_fault | output | 1 | Sticky flag for a blocked write |

## Verification
The bench builds the block with its defaults: 64 tables (`TBL_W`=6), a 12-bit offset, a boot page of 8'hF0 and ports 8'h40 to 8'h43. Random loads, selects and accesses are confined to tables 0 to 7, so that entries written earlier are hit again many times. The wider table number is still exercised through the pointer bits. These values bring the reset boot map, read/write map splits, protected and unprotected writes, a table switch issued in the middle of a memory cycle, and port aliasing through memory writes within a short run.

// File: rtl/pt_pkg.sv
package pt_pkg;

    localparam int PT_PPN_W = 8;

    typedef struct packed {
        logic                prot;
        logic [PT_PPN_W-1:0] ppn;
    } pt_entry_t;

    typedef enum logic [2:0] {
        PK_NONE,
        PK_SEL,
        PK_PTR,
        PK_DATA,
        PK_CLR
    } pt_port_e;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } pt_dir_e;

    function automatic pt_port_e pt_decode(
        input logic [7:0] port,
        input logic [7:0] p_sel,
        input logic [7:0] p_ptr,
        input logic [7:0] p_dat,
        input logic [7:0] p_clr
    );
        if (port == p_sel)      return PK_SEL;
        else if (port == p_ptr) return PK_PTR;
        else if (port == p_dat) return PK_DATA;
        else if (port == p_clr) return PK_CLR;
        else                    return PK_NONE;
    endfunction

endpackage

// File: rtl/pt_io_decode.sv
module pt_io_decode
    import pt_pkg::*;
#(
    parameter logic [7:0] PORT_SEL  = 8'h40,
    parameter logic [7:0] PORT_PTR  = 8'h41,
    parameter logic [7:0] PORT_DATA = 8'h42,
    parameter logic [7:0] PORT_CLR  = 8'h43
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       iorq,
    input  logic       wr,
    input  logic [7:0] port,
    output pt_port_e   io_hit
);
    logic io_lvl;
    logic io_q;

    assign io_lvl = iorq & wr;

    always_ff @(posedge clk) begin
        if (rst) io_q <= 1'b0;
        else     io_q <= io_lvl;
    end

    always_comb begin
        if (io_lvl && !io_q)
            io_hit = pt_decode(port, PORT_SEL, PORT_PTR, PORT_DATA, PORT_CLR);
        else
            io_hit = PK_NONE;
    end
endmodule

// File: rtl/pt_table_sel.sv
module pt_table_sel #(
    parameter int TBL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_wr,
    input  logic [7:0]       din,
    input  logic             mem_start,
    output logic [TBL_W-1:0] eff_tbl
);
    logic [TBL_W-1:0] pend_tbl;
    logic [TBL_W-1:0] cur_tbl;

    assign eff_tbl = mem_start ? pend_tbl : cur_tbl;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_tbl <= '0;
            cur_tbl  <= '0;
        end else begin
            if (sel_wr)    pend_tbl <= din[TBL_W-1:0];
            if (mem_start) cur_tbl  <= pend_tbl;
        end
    end
endmodule

// File: rtl/pt_xlat_ram.sv
module pt_xlat_ram
    import pt_pkg::*;
#(
    parameter int                    TBL_W    = 6,
    parameter int                    IDX_W    = 4,
    parameter logic [PT_PPN_W-1:0]   BOOT_PPN = 8'hF0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [TBL_W+IDX_W:0]     w_idx,
    input  pt_entry_t                w_ent,
    input  logic [TBL_W+IDX_W:0]     r_idx,
    output pt_entry_t                r_ent
);
    localparam int AW    = TBL_W + IDX_W + 1;
    localparam int DEPTH = 1 << AW;
    localparam int BOOTN = 1 << IDX_W;

    pt_entry_t mem [DEPTH];

    assign r_ent = mem[r_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (i < BOOTN) mem[i] <= '{prot: 1'b0, ppn: BOOT_PPN};
                else           mem[i] <= '0;
            end
        end else if (we) begin
            mem[w_idx] <= w_ent;
        end
    end
endmodule

// File: rtl/pt_wp_guard.sv
module pt_wp_guard (
    input  logic clk,
    input  logic rst,
    input  logic mreq,
    input  logic wr,
    input  logic ent_prot,
    input  logic clr,
    output logic inhibit,
    output logic fault
);
    assign inhibit = mreq & wr & ent_prot;

    always_ff @(posedge clk) begin
        if (rst)          fault <= 1'b0;
        else if (inhibit) fault <= 1'b1;
        else if (clr)     fault <= 1'b0;
    end
endmodule

// File: rtl/page_xlat_mmu.sv
module page_xlat_mmu
    import pt_pkg::*;
#(
    parameter int                  CPU_AW    = 16,
    parameter int                  OFF_W     = 12,
    parameter int                  TBL_W     = 6,
    parameter logic [PT_PPN_W-1:0] BOOT_PPN  = 8'hF0,
    parameter logic [7:0]          PORT_SEL  = 8'h40,
    parameter logic [7:0]          PORT_PTR  = 8'h41,
    parameter logic [7:0]          PORT_DATA = 8'h42,
    parameter logic [7:0]          PORT_CLR  = 8'h43
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CPU_AW-1:0]          cpu_addr,
    input  logic [7:0]                 cpu_din,
    input  logic                       mreq,
    input  logic                       iorq,
    input  logic                       wr,
    output logic [PT_PPN_W+OFF_W-1:0]  phys_addr,
    output logic                       wr_inhibit,
    output logic                       wp_fault
);
    localparam int IDX_W = CPU_AW - OFF_W;
    localparam int AW    = TBL_W + IDX_W + 1;

    pt_port_e         io_hit;
    logic             mreq_q;
    logic             mem_start;
    logic [TBL_W-1:0] eff_tbl;
    logic [TBL_W-1:0] ptr_tbl;
    pt_dir_e          ptr_dir;
    logic [IDX_W-1:0] ptr_pg;
    logic [AW-1:0]    w_idx;
    logic [AW-1:0]    r_idx;
    pt_entry_t        w_ent;
    pt_entry_t        r_ent;

    pt_io_decode #(
        .PORT_SEL (PORT_SEL),
        .PORT_PTR (PORT_PTR),
        .PORT_DATA(PORT_DATA),
        .PORT_CLR (PORT_CLR)
    ) u_dec (
        .clk   (clk),
        .rst   (rst),
        .iorq  (iorq),
        .wr    (wr),
        .port  (cpu_addr[7:0]),
        .io_hit(io_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) mreq_q <= 1'b0;
        else     mreq_q <= mreq;
    end

    assign mem_start = mreq & ~mreq_q;

    pt_table_sel #(.TBL_W(TBL_W)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .sel_wr   (io_hit == PK_SEL),
        .din      (cpu_din),
        .mem_start(mem_start),
        .eff_tbl  (eff_tbl)
    );

    // load pointer: table from data byte, direction/page from address high byte
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_tbl <= '0;
            ptr_dir <= DIR_RD;
            ptr_pg  <= '0;
        end else if (io_hit == PK_PTR) begin
            ptr_tbl <= cpu_din[TBL_W-1:0];
            ptr_dir <= pt_dir_e'(cpu_addr[8+IDX_W]);
            ptr_pg  <= cpu_addr[8 +: IDX_W];
        end
    end

    assign w_idx = {ptr_tbl, ptr_dir, ptr_pg};
    assign w_ent = '{prot: cpu_addr[8], ppn: cpu_din};
    assign r_idx = {eff_tbl, wr, cpu_addr[CPU_AW-1 -: IDX_W]};

    pt_xlat_ram #(
        .TBL_W   (TBL_W),
        .IDX_W   (IDX_W),
        .BOOT_PPN(BOOT_PPN)
    ) u_ram (
        .clk  (clk),
        .rst  (rst),
        .we   (io_hit == PK_DATA),
        .w_idx(w_idx),
        .w_ent(w_ent),
        .r_idx(r_idx),
        .r_ent(r_ent)
    );

    assign phys_addr = {r_ent.ppn, cpu_addr[OFF_W-1:0]};

    pt_wp_guard u_guard (
        .clk     (clk),
        .rst     (rst),
        .mreq    (mreq),
        .wr      (wr),
        .ent_prot(r_ent.prot),
        .clr     (io_hit == PK_CLR),
        .inhibit (wr_inhibit),
        .fault   (wp_fault)
    );
endmodule

// File: rtl/page_xlat_mmu_chk.sv
module page_xlat_mmu_chk #(
    parameter int         CPU_AW   = 16,
    parameter int         OFF_W    = 12,
    parameter int         PHYS_W   = 20,
    parameter logic [7:0] BOOT_PPN = 8'hF0,
    parameter logic [7:0] PORT_CLR = 8'h43
) (
    input logic              clk,
    input logic              rst,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic              mreq,
    input logic              iorq,
    input logic              wr,
    input logic [PHYS_W-1:0] phys_addr,
    input logic              wr_inhibit,
    input logic              wp_fault
);
    logic io_q;
    logic clr_go;

    always_ff @(posedge clk) begin
        if (rst) io_q <= 1'b0;
        else     io_q <= iorq & wr;
    end

    assign clr_go = iorq && wr && !io_q && (cpu_addr[7:0] == PORT_CLR);

    p_offset_pass_r1: assert property (@(posedge clk) disable iff (rst)
        phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

    p_boot_map_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) && !wr |-> phys_addr[PHYS_W-1:OFF_W] == BOOT_PPN);

    p_hold_in_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        mreq && $past(mreq) && $stable(cpu_addr) && $stable(wr) && !iorq && !$past(iorq)
        |-> $stable(phys_addr));

    p_inhibit_on_write_r7: assert property (@(posedge clk) disable iff (rst)
        wr_inhibit |-> mreq && wr);

    p_fault_set_r9: assert property (@(posedge clk) disable iff (rst)
        wr_inhibit |=> wp_fault);

    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        wp_fault && !clr_go |=> wp_fault);

    p_fault_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(wp_fault) |-> $past(wr_inhibit));
endmodule

bind page_xlat_mmu page_xlat_mmu_chk #(
    .CPU_AW  (CPU_AW),
    .OFF_W   (OFF_W),
    .PHYS_W  (pt_pkg::PT_PPN_W + OFF_W),
    .BOOT_PPN(BOOT_PPN),
    .PORT_CLR(PORT_CLR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .mreq      (mreq),
    .iorq      (iorq),
    .wr        (wr),
    .phys_addr (phys_addr),
    .wr_inhibit(wr_inhibit),
    .wp_fault  (wp_fault)
);

// File: tb/tb_page_xlat_mmu.sv
module tb_page_xlat_mmu;
    localparam int TBL_W = 6;
    localparam int DEPTH = 1 << (TBL_W + 5);
    localparam logic [7:0] BOOT = 8'hF0;
    localparam logic [7:0] P_SEL = 8'h40, P_PTR = 8'h41, P_DAT = 8'h42, P_CLR = 8'h43;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_din = '0;
    logic        mreq = 1'b0, iorq = 1'b0, wr = 1'b0;
    logic [19:0] phys_addr;
    logic        wr_inhibit, wp_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [8:0] m_mem [DEPTH];
    int m_pend, m_cur, m_ptr;
    bit m_fault;

    always #2 clk = ~clk;

    page_xlat_mmu #(.TBL_W(TBL_W)) dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
        .mreq(mreq), .iorq(iorq), .wr(wr),
        .phys_addr(phys_addr), .wr_inhibit(wr_inhibit), .wp_fault(wp_fault)
    );

    function automatic int idx(int t, int d, int p);
        return (t << 5) | (d << 4) | p;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_mem[i] = (i < 16) ? {1'b0, BOOT} : 9'h0;
        m_pend = 0; m_cur = 0; m_ptr = 0; m_fault = 0;
    endtask

    task automatic io_wr(input logic [7:0] port, input logic [7:0] hi, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = {hi, port}; cpu_din = d; iorq = 1'b1; wr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        iorq = 1'b0; wr = 1'b0;
        case (port)
            P_SEL: m_pend = int'(d) % (1 << TBL_W);
            P_PTR: m_ptr = idx(int'(d) % (1 << TBL_W), int'(hi[4]), int'(hi[3:0]));
            P_DAT: m_mem[m_ptr] = {hi[0], d};
            P_CLR: m_fault = 0;
            default: ;
        endcase
    endtask

    task automatic load(input int t, input int d, input int p, input logic [7:0] ppn, input bit prot);
        io_wr(P_PTR, {3'b0, d[0], p[3:0]}, t[7:0]);
        io_wr(P_DAT, {7'b0, prot}, ppn);
    endtask

    task automatic mem_acc(input string tag, input logic [15:0] a, input bit w, input logic [7:0] d);
        logic [8:0] e;
        bit exp_inh;
        @(negedge clk);
        cpu_addr = a; wr = w; mreq = 1'b1; cpu_din = d;
        m_cur = m_pend;
        #1;
        e = m_mem[idx(m_cur, int'(w), int'(a[15:12]))];
        chk({tag, " phys"}, 32'(phys_addr), 32'({e[7:0], a[11:0]}));
        exp_inh = w && e[8];
        chk("R7 inhibit", 32'(wr_inhibit), 32'(exp_inh));
        if (exp_inh) m_fault = 1;
        @(negedge clk);
        chk("R6 phys held in cycle", 32'(phys_addr), 32'({e[7:0], a[11:0]}));
        mreq = 1'b0; wr = 1'b0;
        #1;
        chk("R9 fault", 32'(wp_fault), 32'(m_fault));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] a0;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R2 reset state
        chk("R2 fault after reset", 32'(wp_fault), 32'h0);
        chk("R2 inhibit after reset", 32'(wr_inhibit), 32'h0);
        mem_acc("R2 boot page 0", 16'h0123, 1'b0, 8'h00);
        mem_acc("R2 boot page 5", 16'h5abc, 1'b0, 8'h00);
        mem_acc("R2 boot page 15 R1", 16'hffff, 1'b0, 8'h00);
        mem_acc("R2 table0 write map", 16'h3456, 1'b1, 8'h00);

        // R3 R4 R5 split read/write maps
        load(3, 0, 2, 8'h55, 1'b0);
        load(3, 1, 2, 8'h66, 1'b0);
        io_wr(P_SEL, 8'h00, 8'd3);
        mem_acc("R5 read map", 16'h2abc, 1'b0, 8'h00);
        mem_acc("R5 write map", 16'h2abc, 1'b1, 8'h00);
        mem_acc("R4 untouched page", 16'h7000, 1'b0, 8'h00);

        // R8 protect flag in read map ignored
        load(3, 0, 4, 8'h12, 1'b1);
        mem_acc("R8 read with prot flag", 16'h4001, 1'b0, 8'h00);
        mem_acc("R8 write map unprotected", 16'h4001, 1'b1, 8'h00);

        // R7 R9 protected write and sticky fault
        load(3, 1, 7, 8'h9A, 1'b1);
        mem_acc("R7 protected write", 16'h7fff, 1'b1, 8'h00);
        io_wr(8'h77, 8'h00, 8'h00);
        #1 chk("R9 fault after other port", 32'(wp_fault), 32'h1);
        mem_acc("R9 read keeps fault", 16'h7fff, 1'b0, 8'h00);
        io_wr(P_CLR, 8'h00, 8'h00);
        #1 chk("R9 fault cleared", 32'(wp_fault), 32'h0);

        // R6 select mid-cycle
        load(5, 0, 1, 8'hA1, 1'b0);
        @(negedge clk);
        cpu_addr = 16'h1234; wr = 1'b0; mreq = 1'b1;
        m_cur = m_pend;
        #1 a0 = 16'h1234;
        chk("R6 before switch", 32'(phys_addr), 32'({m_mem[idx(3, 0, 1)][7:0], 12'h234}));
        io_wr(P_SEL, 8'h00, 8'd5);
        cpu_addr = a0; wr = 1'b0;
        #1 chk("R6 table held in cycle", 32'(phys_addr), 32'({m_mem[idx(3, 0, 1)][7:0], 12'h234}));
        @(negedge clk);
        mreq = 1'b0;
        mem_acc("R6 new table next cycle", 16'h1234, 1'b0, 8'h00);

        // R10 aliased memory writes and stray ports
        load(5, 0, 9, 8'h3C, 1'b0);
        mem_acc("R10 mem write to ptr port addr", 16'h9041, 1'b1, 8'h02);
        mem_acc("R10 mem write to sel port addr", 16'h0040, 1'b1, 8'h03);
        io_wr(P_DAT, 8'h00, 8'h4D);
        io_wr(8'h44, 8'h00, 8'h07);
        mem_acc("R10 pointer and table kept", 16'h9000, 1'b0, 8'h00);

        // random mix (R5)
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom % 8);
            if (op < 3)
                load(int'($urandom % 8), int'($urandom % 2), int'($urandom % 16),
                     8'($urandom), ($urandom % 4) == 0);
            else if (op == 3)
                io_wr(P_SEL, 8'h00, 8'($urandom % 8));
            else if (op == 4)
                io_wr(P_CLR, 8'h00, 8'h00);
            else
                mem_acc("R5 random", 16'($urandom), 1'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule